// File: doc/BRIEF.md
# Masked Level Interrupt Concentrator

This block gathers up to sixteen level-sensitive interrupt lines from peripherals and merges them into one interrupt request for the processor. Each line is sampled into a source register every clock, so a source bit simply follows its line. The source bits are ANDed with a software-owned enable mask, and the combined request goes high whenever any enabled source is active.

Software reaches the block through a small 16-bit register window. It has two live halfwords. The first is a read-only vector that names the lowest-numbered enabled active source. The second is the enable mask, which software can read and write. The port takes byte, halfword and word accesses. A byte write merges into the mask without disturbing the other byte. A word access is handled as two halfword accesses at consecutive halfword slots.

Top module: `lvl_irq_concentrator`

## Requirements
- R1: The source register takes the value of `irq_i` at every rising clock edge after reset, so a line change is visible in the vector read one clock after the edge that samples it.
- R2: `irq_o` is registered: it equals the OR of (source register AND mask) as it stood one clock earlier.
- R3: A halfword read at byte offset 0x0 returns the vector: zero when no enabled source is active, otherwise a value whose bits [6:2] hold the winning source index plus one, with all other bits zero.
- R4: When several enabled sources are active, the vector names the one with the lowest index.
- R5: Byte offset 0x2 is the 16-bit mask register. A halfword write there replaces it, and a halfword read returns it.
- R6: While `rst_n` is low at a clock edge, the mask becomes 0x0010, the source register becomes 0 and `irq_o` becomes 0.
- R7: Size code 0 selects a byte access, and `bus_addr[0]` selects the low byte (0) or the high byte (1) of the addressed halfword. A byte write to offset 0x2 or 0x3 changes only that byte of the mask. A byte read returns the selected byte in `bus_rdata[7:0]`, with the upper bits zero.
- R8: Size code 2 selects a word access. It covers the halfword at `bus_addr` (data bits [15:0]) and the next halfword (data bits [31:16]). A word write at 0x0 loads the mask from bits [31:16]. A word read at 0x0 returns {mask, vector}.
- R9: Halfword slots other than 0x0 and 0x2 read as zero and ignore writes. A write to the vector slot is ignored. Size code 3 reads zero and never writes. Size code 1 selects a halfword access, and `bus_addr[0]` is ignored for halfword and word accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_SRC | Level interrupt lines, bit n is source n |
| bus_addr | input | ADDR_W | Byte address inside the register window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 none |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address, size and state |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that `irq_i` and the bus signals are synchronous to `clk` and stable around each rising edge. They also assume that reset is held for at least one edge before any check is relied on. The bench keeps within these limits by changing every input one nanosecond after a rising edge, and it reads only after the combinational path has settled. The vector-shape assertion assumes `NUM_SRC` is no larger than sixteen, so every index plus one fits in bits [6:2]; the default configuration meets this.

// File: rtl/irq_conc_pkg.sv
// Package: shared types and constants for the level interrupt concentrator.
// Assumes a 16-bit register slot width and a 32-bit bus data path.
package irq_conc_pkg;

    localparam int REG_W  = 16;
    localparam int DATA_W = 32;

    // Encoded access size carried on bus_size.
    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_NONE = 2'd3
    } acc_size_e;

endpackage

// File: rtl/irq_src_stage.sv
// Module: samples the level interrupt lines into the source register,
// gates them with the mask and registers the combined request.
// Assumes irq_i is synchronous to clk; no edge latching is done.
module irq_src_stage #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] src_q,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);

    // Level tracking: the source register copies the lines every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= irq_i;
        end
    end

    // Pending sources are the active ones that software has enabled.
    always_comb begin
        pend_o = src_q & mask_i;
    end

    // Combined request, registered to give a clean output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |pend_o;
        end
    end

endmodule

// File: rtl/irq_lowest_enc.sv
// Module: fixed-priority encoder that turns the pending bitmap into the
// software vector ((lowest index + 1) << 2), or zero when idle.
// Assumes NUM_SRC is small enough that (NUM_SRC << 2) fits in VEC_W bits.
module irq_lowest_enc #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = 16
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [VEC_W-1:0]   vec_o
);

    // Scan from the top down so the lowest set bit is written last and wins.
    always_comb begin
        vec_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vec_o = VEC_W'((i + 1) << 2);
            end
        end
    end

endmodule

// File: rtl/irq_reg_port.sv
// Module: register window decode. It holds the mask register and builds
// read data for byte, halfword and word accesses from two halfword slots.
// Assumes bus signals are synchronous and that reads have no side effect.
module irq_reg_port
    import irq_conc_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter logic [REG_W-1:0] MASK_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [REG_W-1:0]  vec_i,
    output logic [REG_W-1:0]  mask_q,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int                HW_ADDR_W = ADDR_W - 1;
    localparam logic [HW_ADDR_W-1:0] VEC_SLOT  = HW_ADDR_W'(0);
    localparam logic [HW_ADDR_W-1:0] MASK_SLOT = HW_ADDR_W'(1);

    acc_size_e            acc;
    logic [HW_ADDR_W-1:0] slot_lo;
    logic [HW_ADDR_W-1:0] slot_hi;
    logic [REG_W-1:0]     rd_lo;
    logic [REG_W-1:0]     rd_hi;
    logic [REG_W-1:0]     mask_d;

    // Halfword slot read mux, shared by the low and high halves.
    function automatic logic [REG_W-1:0] slot_read(
        input logic [HW_ADDR_W-1:0] slot,
        input logic [REG_W-1:0]     vec,
        input logic [REG_W-1:0]     mask
    );
        if (slot == VEC_SLOT) begin
            return vec;
        end else if (slot == MASK_SLOT) begin
            return mask;
        end
        return '0;
    endfunction

    // Decode the access size and the two halfword slots it may touch.
    always_comb begin
        acc     = acc_size_e'(bus_size);
        slot_lo = bus_addr[ADDR_W-1:1];
        slot_hi = slot_lo + HW_ADDR_W'(1);
    end

    // Read data assembly per access size.
    always_comb begin
        rd_lo     = slot_read(slot_lo, vec_i, mask_q);
        rd_hi     = slot_read(slot_hi, vec_i, mask_q);
        bus_rdata = '0;
        unique case (acc)
            ACC_BYTE: bus_rdata[7:0]  = bus_addr[0] ? rd_lo[15:8] : rd_lo[7:0];
            ACC_HALF: bus_rdata[15:0] = rd_lo;
            ACC_WORD: bus_rdata       = {rd_hi, rd_lo};
            default:  bus_rdata       = '0;
        endcase
    end

    // Next mask value: narrow writes merge with the current contents.
    always_comb begin
        mask_d = mask_q;
        if (bus_wr) begin
            unique case (acc)
                ACC_BYTE: begin
                    if (slot_lo == MASK_SLOT) begin
                        if (bus_addr[0]) begin
                            mask_d[15:8] = bus_wdata[7:0];
                        end else begin
                            mask_d[7:0] = bus_wdata[7:0];
                        end
                    end
                end
                ACC_HALF: begin
                    if (slot_lo == MASK_SLOT) begin
                        mask_d = bus_wdata[15:0];
                    end
                end
                ACC_WORD: begin
                    if (slot_lo == MASK_SLOT) begin
                        mask_d = bus_wdata[15:0];
                    end else if (slot_hi == MASK_SLOT) begin
                        mask_d = bus_wdata[31:16];
                    end
                end
                default: mask_d = mask_q;
            endcase
        end
    end

    // Mask register with its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else begin
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/lvl_irq_concentrator.sv
// Module: top of the masked level interrupt concentrator. It ties the
// source stage, the priority encoder and the register window together.
// Assumes NUM_SRC <= 16 and ADDR_W >= 3.
module lvl_irq_concentrator
    import irq_conc_pkg::*;
#(
    parameter int               NUM_SRC  = 16,
    parameter int               ADDR_W   = 12,
    parameter logic [REG_W-1:0] MASK_RST = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] pend;
    logic [REG_W-1:0]   mask_q;
    logic [REG_W-1:0]   vec;
    logic [NUM_SRC-1:0] mask_used;

    // Only the mask bits that have a source behind them take part.
    always_comb begin
        mask_used = mask_q[NUM_SRC-1:0];
    end

    irq_src_stage #(
        .NUM_SRC(NUM_SRC)
    ) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (irq_i),
        .mask_i(mask_used),
        .src_q (src_q),
        .pend_o(pend),
        .irq_o (irq_o)
    );

    irq_lowest_enc #(
        .NUM_SRC(NUM_SRC),
        .VEC_W  (REG_W)
    ) u_enc (
        .pend_i(pend),
        .vec_o (vec)
    );

    irq_reg_port #(
        .ADDR_W  (ADDR_W),
        .MASK_RST(MASK_RST)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .vec_i    (vec),
        .mask_q   (mask_q),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: rtl/irq_conc_checker.sv
// Module: assertion checker for the concentrator, bound to the top.
// Assumes synchronous inputs and reset held across at least one edge.
module irq_conc_checker #(
    parameter int               NUM_SRC  = 16,
    parameter int               ADDR_W   = 12,
    parameter logic [15:0]      MASK_RST = 16'h0010
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [1:0]         bus_size,
    input logic               bus_wr,
    input logic [31:0]        bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] src_q,
    input logic [15:0]        mask_q
);

    logic [NUM_SRC-1:0] pend;
    logic               rd_vec;
    logic               lowest_ok;
    int                 idx;

    // Observed pending set, vector-read qualifier and lowest-index test.
    always_comb begin
        pend      = src_q & mask_q[NUM_SRC-1:0];
        rd_vec    = (bus_size == 2'd1) && (bus_addr[ADDR_W-1:1] == '0);
        idx       = int'(bus_rdata[6:2]) - 1;
        lowest_ok = 1'b0;
        if (idx >= 0 && idx < NUM_SRC) begin
            lowest_ok = pend[idx];
            for (int k = 0; k < NUM_SRC; k++) begin
                if (k < idx && pend[k]) begin
                    lowest_ok = 1'b0;
                end
            end
        end
    end

    // R6: reset leaves the documented values.
    p_reset_values_r6: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_q == MASK_RST && src_q == '0 && !irq_o))
        else $error("p_reset_values_r6");

    // R1: the source register is last cycle's line levels.
    p_src_tracks_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> src_q == $past(irq_i))
        else $error("p_src_tracks_lines_r1");

    // R2: the request reflects the previous cycle's pending set.
    p_irq_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_o == (|$past(pend)))
        else $error("p_irq_one_clock_r2");

    // R3: the vector is zero exactly when nothing is pending.
    p_vector_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vec |-> ((bus_rdata[15:0] == '0) == (pend == '0)))
        else $error("p_vector_zero_r3");

    // R4: a non-zero vector names the lowest pending source.
    p_vector_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && (|pend)) |-> (lowest_ok && bus_rdata[1:0] == 2'b00))
        else $error("p_vector_lowest_r4");

    // R9: without a write strobe the mask holds its value.
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask_q))
        else $error("p_mask_hold_r9");

    // R9: size code 3 never returns data.
    p_none_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size == 2'd3) |-> bus_rdata == '0)
        else $error("p_none_reads_zero_r9");

endmodule

bind lvl_irq_concentrator irq_conc_checker #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .MASK_RST(MASK_RST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_i),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .src_q    (src_q),
    .mask_q   (mask_q)
);

// File: tb/sim_lvl_irq_concentrator.sv
module sim_lvl_irq_concentrator;

    localparam int NS = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_i = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd1;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    lvl_irq_concentrator #(.NUM_SRC(NS), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, input int size, output logic [31:0] data);
        bus_addr = AW'(addr);
        bus_size = 2'(size);
        bus_wr   = 1'b0;
        #1;
        data = bus_rdata;
    endtask

    task automatic wr(input int addr, input int size, input logic [31:0] data);
        bus_addr  = AW'(addr);
        bus_size  = 2'(size);
        bus_wdata = data;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    function automatic logic [31:0] exp_vec(input logic [NS-1:0] p);
        for (int i = 0; i < NS; i++) begin
            if (p[i]) return 32'((i + 1) * 4);
        end
        return 32'h0;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [15:0] m;
        logic [NS-1:0] s;

        // R6: reset state
        repeat (3) tick();
        check("R6 irq_o in reset", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        tick();
        rd(2, 1, d); check("R6 mask reset", d, 32'h0010);
        rd(0, 1, d); check("R6 vector reset", d, 32'h0);

        // R1/R2: latency through source register and output register
        irq_i = NS'(1) << 4;
        tick();
        rd(0, 1, d); check("R1 vector after one edge", d, 32'd20);
        check("R2 irq_o not yet", 32'(irq_o), 32'h0);
        tick();
        check("R2 irq_o after two edges", 32'(irq_o), 32'h1);
        irq_i = '0;
        tick();
        check("R2 irq_o holds one clock", 32'(irq_o), 32'h1);
        rd(0, 1, d); check("R1 source cleared on low", d, 32'h0);
        tick();
        check("R2 irq_o falls", 32'(irq_o), 32'h0);

        // R3: active but masked source gives no vector and no request
        irq_i = NS'(1) << 3;
        tick(); tick();
        check("R2 masked source no irq", 32'(irq_o), 32'h0);
        rd(0, 1, d); check("R3 masked source vector zero", d, 32'h0);

        // R5: halfword mask write, then latency from mask change
        wr(2, 1, 32'h0000_FFFF);
        check("R2 irq_o one clock after mask", 32'(irq_o), 32'h0);
        rd(2, 1, d); check("R5 mask readback", d, 32'hFFFF);
        tick();
        check("R2 irq_o after mask write", 32'(irq_o), 32'h1);

        // R3/R4: every single source
        for (int i = 0; i < NS; i++) begin
            irq_i = NS'(1) << i;
            tick();
            rd(0, 1, d); check("R3 single source vector", d, 32'((i + 1) << 2));
        end

        // R4: every pair, lower index wins
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j < NS; j++) begin
                irq_i = (NS'(1) << i) | (NS'(1) << j);
                tick();
                rd(0, 1, d); check("R4 pair priority", d, 32'((i + 1) << 2));
            end
        end

        // R2/R3/R4/R5: random masks and sources
        for (int k = 0; k < 300; k++) begin
            rng = next_rng(rng); m = rng[15:0];
            rng = next_rng(rng); s = NS'(rng[31:16]);
            if (k % 4 == 0) s = s & NS'(rng[15:0]);
            irq_i = s;
            wr(2, 1, {16'h0, m});
            rd(0, 1, d); check("R4 random vector", d, exp_vec(s & m));
            rd(2, 1, d); check("R5 random mask", d, {16'h0, m});
            tick();
            check("R2 random irq_o", 32'(irq_o), 32'(|(s & m)));
        end

        // R7: byte writes merge, byte reads select
        wr(2, 1, 32'h0000_1234);
        wr(2, 0, 32'hFFFF_FFAB);
        rd(2, 1, d); check("R7 low byte merge", d, 32'h12AB);
        wr(3, 0, 32'h0000_00CD);
        rd(2, 1, d); check("R7 high byte merge", d, 32'hCDAB);
        rd(2, 0, d); check("R7 byte read low", d, 32'hAB);
        rd(3, 0, d); check("R7 byte read high", d, 32'hCD);
        irq_i = NS'(1) << 15;
        tick();
        rd(0, 0, d); check("R7 vector low byte", d, 32'h40);
        rd(1, 0, d); check("R7 vector high byte", d, 32'h00);

        // R8: word accesses split into halfwords
        wr(0, 2, 32'h5A5A_0000);
        rd(2, 1, d); check("R8 word write at 0 loads mask", d, 32'h5A5A);
        irq_i = NS'(1) << 1;
        tick();
        rd(0, 2, d); check("R8 word read at 0", d, 32'h5A5A_0008);
        wr(2, 2, 32'hFFFF_0F0F);
        rd(2, 2, d); check("R8 word read at 2", d, 32'h0000_0F0F);
        rd(1, 1, d); check("R9 halfword ignores bit0", d, 32'h0000_0008);

        // R9: unknown slots, vector slot write, size code 3
        wr(0, 1, 32'h0000_FFFF);
        rd(2, 1, d); check("R9 vector slot write ignored", d, 32'h0F0F);
        for (int a = 4; a < 64; a += 2) begin
            wr(a, 1, 32'hFFFF_FFFF);
            rd(a, 1, d); check("R9 unknown slot reads zero", d, 32'h0);
        end
        wr(4094, 1, 32'h0000_0000);
        rd(2, 1, d); check("R9 unknown writes ignored", d, 32'h0F0F);
        wr(2, 3, 32'h0000_0000);
        rd(2, 1, d); check("R9 size 3 write ignored", d, 32'h0F0F);
        rd(2, 3, d); check("R9 size 3 reads zero", d, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule